// File: doc/BRIEF.md
# Maskable Interrupt Flag Register

This block gathers three single-cycle event pulses (periodic tick, alarm match and end of time update) into sticky flags, combines them with a software-written enable mask, and drives an active-low, open-drain interrupt request. The request pin is modelled as an output enable: when `irq_drive` is 1 the pad pulls the line low, and when it is 0 the line is released.

Software reads a status byte. The read is framed by a read-active strobe. The byte is captured on the rising edge of the strobe. Every flag is cleared on the falling edge. An event that arrives while the strobe is high is held in a pending register and lands in the flags once the read ends, so no event is lost and none is cleared before it has been seen.

A synchronous reset clears the mask, the flags, the pending events and the captured byte. A strobe that reports the clock-hold control being written to 1 clears the update-ended enable.

Top module: `irq_flag_unit`

## Requirements
- R1: The captured status byte holds the aggregate request in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bits 3 to 0 are 0. The byte is taken from the state before the rising edge of `rd_active` and appears on `rd_data` one cycle later. It holds until the next rising edge.
- R2: An event pulse sets its flag whatever the state of its enable bit. The flag is visible in the next captured byte.
- R3: `irq_drive` is 1 exactly when some flag and its matching enable are both 1. It tracks the flag and enable registers with no added delay.
- R4: Writing an enable bit to 1 while its flag is already set raises `irq_drive` in the cycle after the write.
- R5: At the falling edge of `rd_active`, every flag set when the read began is cleared, and so is the aggregate bit. `irq_drive` drops in the same cycle.
- R6: An event arriving while `rd_active` is high leaves the flags unchanged during the read. The event sets its flag in the cycle after the falling edge.
- R7: While `rst` is high at a clock edge, the enables, flags, pending events and captured byte are cleared, and `irq_drive` is 0.
- R8: A `hold_set` pulse clears the update enable (bit 0 of `en_state`). This takes priority over an enable write in the same cycle.
- R9: An `en_wr` pulse loads `en_wdata`, with bit 2 periodic, bit 1 alarm and bit 0 update. The new value shows on `en_state` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| en_wr | input | 1 | Enable mask write strobe |
| en_wdata | input | 3 | Enable mask value {periodic, alarm, update} |
| hold_set | input | 1 | Clock-hold written to 1; clears update enable |
| rd_active | input | 1 | Status read strobe, high for the read duration |
| rd_data | output | 8 | Captured status byte |
| en_state | output | 3 | Current enable mask |
| irq_drive | output | 1 | 1 = pull the open-drain request line low |

## Verification
Several faults show up at the ports within one cycle of the stimulus that exercises them. A flag stuck low or a lost pending event shows in the next captured byte. A wrong mask or aggregate term shows at once on `irq_drive`. A clear applied on the wrong strobe edge shows as a wrong `rd_data` or request level in the cycle after that edge. A cycle-accurate model of the requirements is compared every cycle under random events, reads and mask writes, together with directed cases:
- an event on the capture edge
- an event on the release edge
- enabling an already-set flag
- a `hold_set` pulse colliding with a write

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_UPD = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PER = 2;

  typedef struct packed {
    logic in_read;
    logic close;
  } rd_ctrl_t;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic in_read,
  input  logic close,
  output logic flag_d,
  output logic flag_q,
  output logic pend_q
);
  logic pend_d;

  always_comb begin
    flag_d = flag_q;
    pend_d = pend_q;
    if (in_read) begin
      pend_d = pend_q | evt;
    end else if (close) begin
      flag_d = pend_q | evt;
      pend_d = 1'b0;
    end else begin
      flag_d = flag_q | evt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      pend_q <= pend_d;
    end
  end

  assert_flag_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    in_read |=> $stable(flag_q));
  assert_event_held_R6: assert property (@(posedge clk) disable iff (rst)
    (evt && in_read) |=> pend_q);
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (evt && !in_read) |=> flag_q);
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int NSRC    = 3,
  parameter int UPD_IDX = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [NSRC-1:0] wdata,
  input  logic            hold_set,
  output logic [NSRC-1:0] en_d,
  output logic [NSRC-1:0] en_q
);
  always_comb begin
    en_d = wr ? wdata : en_q;
    if (hold_set) en_d[UPD_IDX] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end

  assert_hold_clears_upd_R8: assert property (@(posedge clk) disable iff (rst)
    hold_set |=> !en_q[UPD_IDX]);
  assert_write_loads_R9: assert property (@(posedge clk) disable iff (rst)
    (wr && !hold_set) |=> (en_q == $past(wdata)));
endmodule

// File: rtl/irq_read_seq.sv
module irq_read_seq
  import irq_flag_pkg::*;
#(
  parameter int NSRC   = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_active,
  input  logic [NSRC-1:0]   flags,
  input  logic              agg,
  output rd_ctrl_t          ctrl,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FLAG_LSB = DATA_W - 1 - NSRC;

  logic              rd_q;
  logic              open_edge;
  logic [DATA_W-1:0] snap_d;
  logic [DATA_W-1:0] snap_q;

  assign open_edge    = rd_active & ~rd_q;
  assign ctrl.in_read = rd_active;
  assign ctrl.close   = rd_q & ~rd_active;

  always_comb begin
    snap_d = '0;
    snap_d[DATA_W-1] = agg;
    snap_d[FLAG_LSB +: NSRC] = flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      snap_q <= '0;
    end else begin
      rd_q <= rd_active;
      if (open_edge) snap_q <= snap_d;
    end
  end

  assign rd_data = snap_q;

  assert_snap_stable_R1: assert property (@(posedge clk) disable iff (rst)
    !open_edge |=> $stable(snap_q));
  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> (snap_q == '0));
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_periodic,
  input  logic              evt_alarm,
  input  logic              evt_update,
  input  logic              en_wr,
  input  logic [NSRC-1:0]   en_wdata,
  input  logic              hold_set,
  input  logic              rd_active,
  output logic [DATA_W-1:0] rd_data,
  output logic [NSRC-1:0]   en_state,
  output logic              irq_drive
);
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] flag_d, flag_q, pend_q;
  logic [NSRC-1:0] en_d, en_q;
  rd_ctrl_t        ctrl;
  logic            agg;
  logic            irq_q;

  always_comb begin
    evt          = '0;
    evt[SRC_PER] = evt_periodic;
    evt[SRC_ALM] = evt_alarm;
    evt[SRC_UPD] = evt_update;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_cell
    irq_flag_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt[i]),
      .in_read (ctrl.in_read),
      .close   (ctrl.close),
      .flag_d  (flag_d[i]),
      .flag_q  (flag_q[i]),
      .pend_q  (pend_q[i])
    );
  end

  irq_enable_reg #(.NSRC(NSRC), .UPD_IDX(SRC_UPD)) u_en (
    .clk      (clk),
    .rst      (rst),
    .wr       (en_wr),
    .wdata    (en_wdata),
    .hold_set (hold_set),
    .en_d     (en_d),
    .en_q     (en_q)
  );

  assign agg = |(flag_q & en_q);

  irq_read_seq #(.NSRC(NSRC), .DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_active (rd_active),
    .flags     (flag_q),
    .agg       (agg),
    .ctrl      (ctrl),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_d & en_d);
  end

  assign irq_drive = irq_q;
  assign en_state  = en_q;

  assert_irq_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    irq_drive == |(flag_q & en_q));
  assert_close_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.close && !(|pend_q) && !(|evt)) |=> (flag_q == '0 && !irq_drive));
  assert_reset_quiet_R7: assert property (@(posedge clk)
    rst |=> (!irq_drive && en_state == '0));
endmodule

// File: tb/irq_flag_unit_tb_top.sv
module irq_flag_unit_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       evt_periodic, evt_alarm, evt_update;
  logic       en_wr;
  logic [2:0] en_wdata;
  logic       hold_set;
  logic       rd_active;
  logic [7:0] rd_data;
  logic [2:0] en_state;
  logic       irq_drive;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [2:0] m_flag, m_pend, m_en;
  logic [7:0] m_snap;
  logic       m_rdq;

  always #(CLK_P/2) clk = ~clk;

  irq_flag_unit dut_i (
    .clk(clk), .rst(rst),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .en_wr(en_wr), .en_wdata(en_wdata), .hold_set(hold_set),
    .rd_active(rd_active), .rd_data(rd_data), .en_state(en_state),
    .irq_drive(irq_drive)
  );

  function automatic logic [7:0] status_byte(logic [2:0] f, logic [2:0] e);
    return {|(f & e), f, 4'b0000};
  endfunction

  task automatic check(input logic ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [2:0] ev;
    logic rise, fall;
    ev = {evt_periodic, evt_alarm, evt_update};
    if (rst) begin
      m_flag = 0; m_pend = 0; m_en = 0; m_snap = 0; m_rdq = 0;
    end else begin
      rise = rd_active & ~m_rdq;
      fall = ~rd_active & m_rdq;
      if (rise) m_snap = status_byte(m_flag, m_en);
      if (rd_active) m_pend = m_pend | ev;
      else if (fall) begin m_flag = m_pend | ev; m_pend = 0; end
      else m_flag = m_flag | ev;
      if (en_wr) m_en = en_wdata;
      if (hold_set) m_en[0] = 1'b0;
      m_rdq = rd_active;
    end
  endtask

  // advance one clock, then compare all outputs with the model
  task automatic step(input string tag);
    model_edge();
    @(posedge clk); #1;
    check(irq_drive == |(m_flag & m_en), {tag, " R3 irq"}, {7'b0, irq_drive},
          {7'b0, |(m_flag & m_en)});
    check(rd_data == m_snap, {tag, " R1 rd_data"}, rd_data, m_snap);
    check(en_state == m_en, {tag, " R9 en_state"}, {5'b0, en_state}, {5'b0, m_en});
    evt_periodic = 0; evt_alarm = 0; evt_update = 0;
    en_wr = 0; hold_set = 0;
  endtask

  task automatic do_read(input string tag);
    rd_active = 1; step(tag);
    rd_active = 1; step(tag);
    rd_active = 0; step(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; evt_periodic = 0; evt_alarm = 0; evt_update = 0;
    en_wr = 0; en_wdata = 0; hold_set = 0; rd_active = 0;
    m_flag = 0; m_pend = 0; m_en = 0; m_snap = 0; m_rdq = 0;
    step("R7 reset"); step("R7 reset");
    rst = 0;
    check(irq_drive == 0 && rd_data == 0 && en_state == 0, "R7 reset state",
          rd_data, 8'h00);

    // R2: flags set with enables off, no request
    evt_periodic = 1; evt_update = 1; step("R2 set masked");
    check(irq_drive == 0, "R2 masked no irq", {7'b0, irq_drive}, 8'h00);
    do_read("R2 read");
    check(rd_data == 8'h50, "R2 flags visible R1 layout", rd_data, 8'h50);
    check(irq_drive == 0, "R5 cleared", {7'b0, irq_drive}, 8'h00);

    // R4: enable an already-set flag
    evt_alarm = 1; step("R4 set alarm");
    en_wr = 1; en_wdata = 3'b010; step("R4 enable");
    check(irq_drive == 1, "R4 immediate irq", {7'b0, irq_drive}, 8'h01);

    // R6: event on capture edge and mid read is deferred
    rd_active = 1; evt_periodic = 1; step("R6 open");
    rd_active = 1; evt_update = 1; step("R6 mid");
    check(rd_data == 8'hA0, "R1 snapshot agg+alarm", rd_data, 8'hA0);
    check(irq_drive == 1, "R6 flags frozen in read", {7'b0, irq_drive}, 8'h01);
    rd_active = 0; step("R6 close");
    check(irq_drive == 0, "R5 alarm cleared", {7'b0, irq_drive}, 8'h00);
    do_read("R6 reread");
    check(rd_data == 8'h50, "R6 deferred flags", rd_data, 8'h50);

    // R6: event on the release edge lands
    rd_active = 1; step("R6 open2");
    rd_active = 0; evt_alarm = 1; step("R6 release evt");
    check(irq_drive == 1, "R6 release-edge event", {7'b0, irq_drive}, 8'h01);
    do_read("R6 drain");

    // R8: hold_set beats write
    en_wr = 1; en_wdata = 3'b111; hold_set = 1; step("R8 collide");
    check(en_state == 3'b110, "R8 hold clears update", {5'b0, en_state}, 8'h06);
    evt_update = 1; step("R8 upd masked");
    check(irq_drive == 0, "R8 update masked", {7'b0, irq_drive}, 8'h00);

    // R7: reset mid-operation
    evt_periodic = 1; step("R7 pre");
    rst = 1; step("R7 mid reset");
    rst = 0;
    check(irq_drive == 0 && en_state == 0 && rd_data == 0, "R7 cleared",
          {5'b0, en_state}, 8'h00);

    // random phase, fixed seed
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      evt_periodic = ($urandom % 8) == 0;
      evt_alarm    = ($urandom % 10) == 0;
      evt_update   = ($urandom % 9) == 0;
      en_wr        = ($urandom % 12) == 0;
      en_wdata     = 3'($urandom);
      hold_set     = ($urandom % 25) == 0;
      if (($urandom % 5) == 0) rd_active = ~rd_active;
      step("rand");
    end
    rd_active = 0; step("end");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule